// File: doc/BRIEF.md
# Untagged Branch Direction Predictor Table

This block guesses, every cycle, whether the conditional branch at the current fetch address will be taken. It keeps a table of small history entries and selects one entry straight from a slice of the instruction address. No tag is stored, so branches whose index bits match share an entry. The guess is formed combinationally from the fetch address, so the fetch stage can act on it in the same cycle.

When a conditional branch resolves later in the pipeline, the outcome comes back through a separate update port and is written into the entry on the next clock edge. A build-time parameter selects the entry type. A one-bit entry simply repeats the last outcome. A two-bit saturating counter adds hysteresis, so one odd outcome from a settled state does not flip the guess.

Top module: `dirpred_table`

## Requirements
- R1: The entry is selected by address bits [9:2] (256 entries). Addresses that differ only in bits [1:0] or [31:10] use the same entry, and the block raises no error for this sharing.
- R2: Synchronous active-low reset sets every entry to its not-taken initial value: 2'b01 (weakly not taken) for the counter type and 0 for the one-bit type. After reset, every address predicts not taken.
- R3: With the one-bit type, a stored 1 predicts taken and a stored 0 predicts not taken. A valid update overwrites the entry with the resolved outcome.
- R4: With the counter type, the values 2 and 3 predict taken and the values 0 and 1 predict not taken.
- R5: With the counter type, a taken update adds one to the entry, and an entry at 3 stays at 3.
- R6: With the counter type, a not-taken update subtracts one from the entry, and an entry at 0 stays at 0.
- R7: While the update strobe is low, the table does not change, whatever the update address and outcome inputs hold.
- R8: If a lookup and a valid update select the same entry in the same cycle, the lookup returns the value held before that update.
- R9: For a branch that repeats the pattern taken, taken, taken, not taken, a warmed-up counter entry mispredicts once per pattern, and a one-bit entry mispredicts twice per pattern.
- R10: An update changes only the entry that its address selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 32 | Address being fetched; selects the entry to read |
| pred_taken | output | 1 | Guess for the fetched branch: 1 = taken |
| upd_valid | input | 1 | Strobe: write back a resolved outcome this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |

## Verification
The bench goes after the counter limits: a design that wraps instead of saturating turns a strong taken entry into strongly not taken after one extra taken outcome, and the guesses that follow are wrong. It also drives a lookup and an update at the same entry in one cycle. A design that forwards the new value there gives the guess too early. Address aliasing is exercised with differing upper and lower bits; a design that uses the wrong index bits splits the shared entry, or merges entries that should stay separate. The loop pattern is run on both entry types, with the update strobe held low against random update inputs, so a table that is written without the strobe gives a wrong misprediction count or a diverging guess.

// File: rtl/bp_pkg.sv
// Package: shared types for the direction predictor.
// Assumes: nothing; pure type and constant definitions.
package bp_pkg;

    // Entry flavour chosen at build time.
    typedef enum logic {
        ENTRY_LAST = 1'b0,   // one bit, repeats the last outcome
        ENTRY_SAT2 = 1'b1    // two-bit saturating counter
    } entry_kind_e;

    // Width of one entry for a given flavour.
    function automatic int entry_width(entry_kind_e kind);
        return (kind == ENTRY_SAT2) ? 2 : 1;
    endfunction

endpackage

// File: rtl/bp_index_slice.sv
// Module: bp_index_slice
// Cuts the table index out of an instruction address.
// Assumes: IDX_LSB + IDX_W <= ADDR_W; bits outside the slice are ignored on purpose.
module bp_index_slice #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    // Bits not in the slice have no effect; gathered here to mark them as intentionally unused.
    logic unused_addr_bits;

    // Purpose: take the index field.
    always_comb begin
        idx              = addr[IDX_LSB +: IDX_W];
        unused_addr_bits = ^addr;
    end

endmodule

// File: rtl/bp_entry_pred.sv
// Module: bp_entry_pred
// Turns one stored entry into a taken / not-taken guess.
// Assumes: the counter flavour holds an unsigned value whose top bit means taken.
module bp_entry_pred #(
    parameter bp_pkg::entry_kind_e KIND = bp_pkg::ENTRY_SAT2,
    parameter int EW = bp_pkg::entry_width(KIND)
) (
    input  logic [EW-1:0] entry,
    output logic          taken
);

    // Purpose: the most significant bit carries the guess for both flavours.
    always_comb begin
        taken = entry[EW-1];
    end

endmodule

// File: rtl/bp_entry_step.sv
// Module: bp_entry_step
// Computes the new value of an entry from its old value and a resolved outcome.
// Assumes: it is only applied when an update is valid.
module bp_entry_step #(
    parameter bp_pkg::entry_kind_e KIND = bp_pkg::ENTRY_SAT2,
    parameter int EW = bp_pkg::entry_width(KIND)
) (
    input  logic [EW-1:0] cur,
    input  logic          taken,
    output logic [EW-1:0] nxt
);

    localparam logic [EW-1:0] TOP = '1;
    localparam logic [EW-1:0] BOT = '0;
    localparam logic [EW-1:0] ONE = EW'(1);

    generate
        if (KIND == bp_pkg::ENTRY_SAT2) begin : g_sat
            // Purpose: count up on taken, down on not taken, pinned at both ends.
            always_comb begin
                if (taken) begin
                    nxt = (cur == TOP) ? cur : cur + ONE;
                end else begin
                    nxt = (cur == BOT) ? cur : cur - ONE;
                end
            end
        end else begin : g_last
            logic unused_cur;
            // Purpose: the entry becomes the outcome itself.
            always_comb begin
                nxt        = {EW{taken}};
                unused_cur = ^cur;
            end
        end
    endgenerate

endmodule

// File: rtl/dirpred_table.sv
// Module: dirpred_table
// Untagged direction predictor: a table of history entries selected by
// address bits, read combinationally at fetch and written by a resolve port.
// Assumes: update and lookup may hit the same entry; the lookup then sees
// the pre-update value. Sharing of an entry by aliasing branches is normal.
module dirpred_table #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 8,
    parameter bp_pkg::entry_kind_e KIND = bp_pkg::ENTRY_SAT2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int EW      = bp_pkg::entry_width(KIND);
    localparam logic [EW-1:0] INIT_VAL = (KIND == bp_pkg::ENTRY_SAT2) ? EW'(1) : '0;

    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [EW-1:0]    tbl [ENTRIES];
    logic [EW-1:0]    rd_fetch;
    logic [EW-1:0]    rd_upd;
    logic [EW-1:0]    wr_val;

    bp_index_slice #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) i_fetch_slice (
        .addr (fetch_addr),
        .idx  (fetch_idx)
    );

    bp_index_slice #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) i_upd_slice (
        .addr (upd_addr),
        .idx  (upd_idx)
    );

    // Purpose: read both the fetch entry and the entry about to be updated.
    always_comb begin
        rd_fetch = tbl[fetch_idx];
        rd_upd   = tbl[upd_idx];
    end

    bp_entry_pred #(.KIND(KIND), .EW(EW)) i_pred (
        .entry (rd_fetch),
        .taken (pred_taken)
    );

    bp_entry_step #(.KIND(KIND), .EW(EW)) i_step (
        .cur   (rd_upd),
        .taken (upd_taken),
        .nxt   (wr_val)
    );

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_row
            // Purpose: hold one entry; reset to the initial value, write on a matching valid update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl[e] <= INIT_VAL;
                end else if (upd_valid && (upd_idx == IDX_W'(e))) begin
                    tbl[e] <= wr_val;
                end
            end
        end
    endgenerate

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic             chk_v;
    logic             chk_t;
    logic [IDX_W-1:0] chk_idx;
    logic [EW-1:0]    chk_old;
    logic [IDX_W-1:0] chk_other;
    logic [EW-1:0]    chk_other_old;

    // Purpose: remember the last update and one untouched neighbour so the following cycle can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_v         <= 1'b0;
            chk_t         <= 1'b0;
            chk_idx       <= '0;
            chk_old       <= '0;
            chk_other     <= '0;
            chk_other_old <= '0;
        end else begin
            chk_v         <= upd_valid;
            chk_t         <= upd_taken;
            chk_idx       <= upd_idx;
            chk_old       <= rd_upd;
            chk_other     <= upd_idx + IDX_W'(1);
            chk_other_old <= tbl[upd_idx + IDX_W'(1)];
        end
    end

    // R2
    reset_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_taken);

    // R10
    neighbour_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> tbl[chk_other] == chk_other_old);

    generate
        if (KIND == bp_pkg::ENTRY_SAT2) begin : g_sat_chk
            // R5
            taken_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chk_v && chk_t |-> tbl[chk_idx] >= chk_old);
            // R6
            not_taken_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chk_v && !chk_t |-> tbl[chk_idx] <= chk_old);
            // R5
            single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chk_v |-> (tbl[chk_idx] == chk_old) ||
                          (tbl[chk_idx] == chk_old + EW'(1)) ||
                          (tbl[chk_idx] == chk_old - EW'(1)));
        end else begin : g_last_chk
            // R3
            last_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chk_v |-> tbl[chk_idx] == {EW{chk_t}});
        end
    endgenerate

endmodule

// File: tb/test_dirpred_table.sv
module test_dirpred_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic        pred2;
    logic        pred1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m2 [256];
    int m1 [256];
    logic last2, last1;

    always #5 clk = ~clk;

    dirpred_table #(.KIND(bp_pkg::ENTRY_SAT2)) i_dirpred_table (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .pred_taken(pred2),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken));

    dirpred_table #(.KIND(bp_pkg::ENTRY_LAST)) i_dirpred_table_lo (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .pred_taken(pred1),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken));

    // R1: index is address bits [9:2]
    function automatic int ix(logic [31:0] a);
        return int'(a[9:2]);
    endfunction

    function automatic int sat_next(int v, logic t);
        if (t) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m2[i] = 1;
            m1[i] = 0;
        end
    endtask

    // One cycle: drive, check both guesses against the pre-update model, clock, update model.
    task automatic step(logic [31:0] fa, logic uv, logic [31:0] ua, logic ut, string req);
        int e2, e1;
        @(negedge clk);
        fetch_addr = fa;
        upd_valid  = uv;
        upd_addr   = ua;
        upd_taken  = ut;
        #1;
        e2 = (m2[ix(fa)] >= 2) ? 1 : 0;   // R4
        e1 = m1[ix(fa)];                  // R3
        check(pred2 == e2[0], req, "counter guess", int'(pred2), e2);
        check(pred1 == e1[0], req, "one-bit guess", int'(pred1), e1);
        last2 = pred2;
        last1 = pred1;
        @(posedge clk);
        if (uv) begin
            m2[ix(ua)] = sat_next(m2[ix(ua)], ut);
            m1[ix(ua)] = ut ? 1 : 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int miss2, miss1;
        logic [31:0] a, b;
        seed = $urandom(32'h1b2c);
        model_reset();
        do_reset();

        // R2: every entry reads not taken after reset
        for (int i = 0; i < 256; i++) step(32'(i) << 2, 1'b0, '0, 1'b0, "R2");

        // R5 / R4: saturate upward, hysteresis on one not-taken
        a = 32'h0000_0014;
        for (int i = 0; i < 5; i++) step(a, 1'b1, a, 1'b1, "R5");
        step(a, 1'b1, a, 1'b0, "R4");
        step(a, 1'b0, a, 1'b0, "R4");   // counter guess still taken at 2; one-bit now not taken
        step(a, 1'b1, a, 1'b0, "R6");
        for (int i = 0; i < 4; i++) step(a, 1'b1, a, 1'b0, "R6");
        step(a, 1'b1, a, 1'b1, "R6");   // from 0 one taken stays not taken
        step(a, 1'b0, a, 1'b0, "R6");

        // R1: alias through upper and lower bits
        b = 32'h0000_0220;
        for (int i = 0; i < 3; i++) step(b, 1'b1, b, 1'b1, "R1");
        step(32'hABCD_E223, 1'b0, '0, 1'b0, "R1");
        step(32'h0000_0120, 1'b0, '0, 1'b0, "R1");

        // R10: neighbour entry untouched by repeated updates
        for (int i = 0; i < 4; i++) step(32'h0000_0010, 1'b1, 32'h0000_000C, 1'b1, "R10");

        // R8: same-cycle collision, lookup sees old value
        step(32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1, "R8");
        step(32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1, "R8");
        step(32'h0000_0300, 1'b0, '0, 1'b0, "R8");

        // R9: loop T,T,T,N, four passes; count misses on passes 2..4
        a = 32'h0000_0024;
        miss2 = 0;
        miss1 = 0;
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                step(a, 1'b1, a, (k != 3), "R9");
                if (p > 0) begin
                    if (last2 != (k != 3)) miss2++;
                    if (last1 != (k != 3)) miss1++;
                end
            end
        end
        check(miss2 == 3, "R9", "counter misses", miss2, 3);
        check(miss1 == 6, "R9", "one-bit misses", miss1, 6);

        // R7: strobe low with busy update inputs
        for (int i = 0; i < 300; i++) begin
            a = {$urandom, 2'b00} & 32'h0000_003C;
            b = $urandom;
            step(a, 1'b0, {b[31:6], a[5:0]}, b[0], "R7");
        end

        // Random mix, biased to a few entries for collisions
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            a = {$urandom, 2'b00};
            if (r[3:2] != 0) a[9:2] = {4'h0, r[7:4]};
            b = {$urandom, 2'b00};
            if (r[9:8] != 0) b[9:2] = {4'h0, r[13:10]};
            if (r[15:14] == 0) b = a;
            step(a ^ {r[31:16], 14'h0, r[1:0]}, r[20], b, r[21], "R5");
        end

        // R2: reset in the middle of use
        do_reset();
        for (int i = 0; i < 256; i++) step(32'hF000_0000 | (32'(i) << 2), 1'b0, '0, 1'b0, "R2");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule